// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block consumes a stream of 32-bit command words, one per accepted valid/ready transfer, and splits it into headers and the payload words that belong to them. The top four bits of every header select an opcode. The parser decodes that opcode's fields and works out how many payload words follow. It then tags each payload word with the register offset it targets, so that a downstream register file can apply the writes directly.

Register-write payloads carry an offset that steps by one per word, stays fixed, or walks the set bits of a mask. The choice depends on the opcode. Class switches, immediate writes, restart addresses, gather descriptors and lock requests are reported on their own strobes. An unrecognised extended sub-operation raises an error pulse. The block does not fetch gather memory, hold registers or arbitrate locks.

The control core is a five-state machine:

- ST_HEADER waits for a header.
- ST_SEQ streams incrementing writes.
- ST_FIXED streams writes to one offset.
- ST_MASKED walks a class or write mask.
- ST_GATHER_ADDR takes the single address word of a gather.

Transitions:

- From ST_HEADER, a header leads to ST_SEQ, ST_FIXED, ST_MASKED or ST_GATHER_ADDR, or the machine stays in ST_HEADER when the header has no payload.
- ST_SEQ and ST_FIXED return to ST_HEADER when their word counter reaches its last word.
- ST_MASKED returns to ST_HEADER when the remaining mask becomes empty.
- ST_GATHER_ADDR always returns to ST_HEADER after its one word.
- Synchronous reset forces ST_HEADER from any state.

Top module: `cmd_stream_parser`

## Requirements
- R1: `in_ready` is high whenever reset is low, so every word presented with `in_valid` is accepted. A synchronous reset clears `busy` and returns the parser to expecting a header, even in the middle of a payload. The opcode of a header is bits 31:28.
- R2: Opcode 0 (class switch) pulses `class_valid` with `class_id` equal to header bits 15:6. When the 6-bit mask in bits 5:0 is zero, no payload follows.
- R3: With a non-zero class mask, the number of payload words equals the count of ones in the mask. Word k goes to offset (bits 27:16 plus the index of the k-th set bit, lowest bit first), modulo 4096.
- R4: Opcode 1 (stepping write) takes N = bits 15:0 payload words. Word k targets (bits 27:16 + k) modulo 4096. N = 0 means no payload.
- R5: Opcode 2 (fixed write) takes N = bits 15:0 payload words, and all of them target offset bits 27:16.
- R6: Opcode 3 (masked write) uses the 16-bit mask in bits 15:0 in the same way as R3. A zero mask means no payload.
- R7: Opcode 4 pulses `imm_valid` with `imm_offset` equal to bits 27:16 and `imm_data` equal to bits 15:0. No payload follows.
- R8: Opcode 5 pulses `restart_valid` with `restart_addr` equal to the header shifted left by four bits, truncated to 32 bits. No payload follows.
- R9: Opcode 6 (gather) takes exactly one payload word. On that word, `gather_valid` pulses with `gather_addr` equal to the word, together with the header's offset (27:16), insert flag (bit 15), type flag (bit 14) and count (13:0).
- R10: Opcode 14 reads a sub-operation from bits 27:24. Sub-operation 0 pulses `lock_acq_valid` and sub-operation 1 pulses `lock_rel_valid`, each with `lock_index` equal to bits 7:0. Any other sub-operation pulses `ext_error`. None of these has a payload.
- R11: Opcodes 7 to 13 and 15 produce no strobe and no payload. The next word is again a header.
- R12: `busy` is high exactly while payload words are still expected. Payload words assert `wr_valid`/`gather_valid` and never a header strobe. Headers never assert `wr_valid`/`gather_valid`.
- R13: Every strobe appears in the cycle after the word is accepted and lasts one cycle. At most one strobe is high in any cycle. A cycle with `in_valid` low changes neither `busy` nor the position in the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 32 | Command word |
| wr_valid | output | 1 | Register write payload strobe |
| wr_offset | output | 12 | Target register offset |
| wr_data | output | 32 | Register write data |
| class_valid | output | 1 | Class switch strobe |
| class_id | output | 10 | New class id |
| imm_valid | output | 1 | Immediate write strobe |
| imm_offset | output | 12 | Immediate write offset |
| imm_data | output | 16 | Immediate write data |
| restart_valid | output | 1 | Restart strobe |
| restart_addr | output | 32 | Restart address |
| gather_valid | output | 1 | Gather descriptor strobe |
| gather_offset | output | 12 | Gather register offset |
| gather_insert | output | 1 | Gather insert flag |
| gather_type | output | 1 | Gather type flag |
| gather_count | output | 14 | Gather word count |
| gather_addr | output | 32 | Gather address word |
| lock_acq_valid | output | 1 | Lock acquire strobe |
| lock_rel_valid | output | 1 | Lock release strobe |
| lock_index | output | 8 | Lock index |
| ext_error | output | 1 | Unknown extended sub-operation |
| busy | output | 1 | Payload words still expected |

## Verification
The checker assumes the input side never stalls on the parser's account. It also assumes a word offered while `busy` is low is a header, so the extended-opcode check only looks at words accepted in that state. The bench always drives reset high from time zero. It changes inputs just after a rising edge, which keeps every accepted word unambiguous. The sweeps cover all class masks, single-bit and dense write masks, and every extended sub-operation. Headers with wrapping offsets and stalls inside payloads are also driven, and all of this stays within those assumptions.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    parameter int WORD_W  = 32;
    parameter int OP_W    = 4;
    parameter int OFF_W   = 12;
    parameter int CNT_W   = 16;
    parameter int CLS_W   = 10;
    parameter int SMASK_W = 6;
    parameter int GCNT_W  = 14;
    parameter int LOCK_W  = 8;
    parameter int SUB_W   = 4;
    parameter int SHIFT   = 4;
    localparam int IDX_W  = $clog2(CNT_W);

    typedef enum logic [OP_W-1:0] {
        OP_SETCLASS = 4'd0,
        OP_INCR     = 4'd1,
        OP_NONINCR  = 4'd2,
        OP_MASK     = 4'd3,
        OP_IMM      = 4'd4,
        OP_RESTART  = 4'd5,
        OP_GATHER   = 4'd6,
        OP_EXTEND   = 4'd14
    } op_e;

    typedef enum logic [2:0] {
        ST_HEADER,
        ST_SEQ,
        ST_FIXED,
        ST_MASKED,
        ST_GATHER_ADDR
    } state_e;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [OFF_W-1:0]   offset;
        logic [CLS_W-1:0]   class_id;
        logic [SMASK_W-1:0] smask;
        logic [CNT_W-1:0]   wide;
        logic               g_ins;
        logic               g_type;
        logic [GCNT_W-1:0]  g_cnt;
        logic [SUB_W-1:0]   subop;
        logic [LOCK_W-1:0]  lock_idx;
        logic [WORD_W-1:0]  restart;
    } hdr_t;
endpackage

// File: rtl/cmdp_hdr_fields.sv
module cmdp_hdr_fields
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);
    always_comb begin
        hdr.op       = word[WORD_W-1 -: OP_W];
        hdr.offset   = word[CNT_W +: OFF_W];
        hdr.class_id = word[SMASK_W +: CLS_W];
        hdr.smask    = word[SMASK_W-1:0];
        hdr.wide     = word[CNT_W-1:0];
        hdr.g_ins    = word[GCNT_W+1];
        hdr.g_type   = word[GCNT_W];
        hdr.g_cnt    = word[GCNT_W-1:0];
        hdr.subop    = word[WORD_W-OP_W-1 -: SUB_W];
        hdr.lock_idx = word[LOCK_W-1:0];
        hdr.restart  = {word[WORD_W-SHIFT-1:0], {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/cmdp_mask_walk.sv
module cmdp_mask_walk #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) idx = i[IW-1:0];
        end
    end

    assign rest = mask & (mask - 1'b1);
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
    import cmdp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_data,
    output logic                wr_valid,
    output logic [OFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]   wr_data,
    output logic                class_valid,
    output logic [CLS_W-1:0]    class_id,
    output logic                imm_valid,
    output logic [OFF_W-1:0]    imm_offset,
    output logic [CNT_W-1:0]    imm_data,
    output logic                restart_valid,
    output logic [WORD_W-1:0]   restart_addr,
    output logic                gather_valid,
    output logic [OFF_W-1:0]    gather_offset,
    output logic                gather_insert,
    output logic                gather_type,
    output logic [GCNT_W-1:0]   gather_count,
    output logic [WORD_W-1:0]   gather_addr,
    output logic                lock_acq_valid,
    output logic                lock_rel_valid,
    output logic [LOCK_W-1:0]   lock_index,
    output logic                ext_error,
    output logic                busy
);
    hdr_t                hdr;
    state_e              state_q, state_d;
    logic [OFF_W-1:0]    off_q, off_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [CNT_W-1:0]    mask_q, mask_d;
    logic [IDX_W-1:0]    walk_idx;
    logic [CNT_W-1:0]    walk_rest;
    logic [OFF_W-1:0]    g_off_q, g_off_d;
    logic                g_ins_q, g_ins_d, g_type_q, g_type_d;
    logic [GCNT_W-1:0]   g_cnt_q, g_cnt_d;

    logic                wr_v_d, cls_v_d, imm_v_d, rst_v_d, gth_v_d;
    logic                acq_v_d, rel_v_d, err_d;
    logic [OFF_W-1:0]    wr_off_d, imm_off_d;
    logic [WORD_W-1:0]   wr_dat_d, rst_addr_d, gth_addr_d;
    logic [CLS_W-1:0]    cls_id_d;
    logic [CNT_W-1:0]    imm_dat_d;
    logic [LOCK_W-1:0]   lock_idx_d;

    cmdp_hdr_fields u_fields (
        .word (in_data),
        .hdr  (hdr)
    );

    cmdp_mask_walk #(.W(CNT_W), .IW(IDX_W)) u_walk (
        .mask (mask_q),
        .idx  (walk_idx),
        .rest (walk_rest)
    );

    assign in_ready = 1'b1;
    assign busy     = (state_q != ST_HEADER);

    // next-state and next-output logic
    always_comb begin
        state_d    = state_q;
        off_d      = off_q;
        cnt_d      = cnt_q;
        mask_d     = mask_q;
        g_off_d    = g_off_q;
        g_ins_d    = g_ins_q;
        g_type_d   = g_type_q;
        g_cnt_d    = g_cnt_q;
        wr_v_d     = 1'b0;
        cls_v_d    = 1'b0;
        imm_v_d    = 1'b0;
        rst_v_d    = 1'b0;
        gth_v_d    = 1'b0;
        acq_v_d    = 1'b0;
        rel_v_d    = 1'b0;
        err_d      = 1'b0;
        wr_off_d   = wr_offset;
        wr_dat_d   = wr_data;
        cls_id_d   = class_id;
        imm_off_d  = imm_offset;
        imm_dat_d  = imm_data;
        rst_addr_d = restart_addr;
        gth_addr_d = gather_addr;
        lock_idx_d = lock_index;

        unique case (state_q)
            ST_HEADER: begin
                if (in_valid) begin
                    case (op_e'(hdr.op))
                        OP_SETCLASS: begin
                            cls_v_d  = 1'b1;
                            cls_id_d = hdr.class_id;
                            if (hdr.smask != '0) begin
                                mask_d  = CNT_W'(hdr.smask);
                                off_d   = hdr.offset;
                                state_d = ST_MASKED;
                            end
                        end
                        OP_INCR: begin
                            if (hdr.wide != '0) begin
                                cnt_d   = hdr.wide;
                                off_d   = hdr.offset;
                                state_d = ST_SEQ;
                            end
                        end
                        OP_NONINCR: begin
                            if (hdr.wide != '0) begin
                                cnt_d   = hdr.wide;
                                off_d   = hdr.offset;
                                state_d = ST_FIXED;
                            end
                        end
                        OP_MASK: begin
                            if (hdr.wide != '0) begin
                                mask_d  = hdr.wide;
                                off_d   = hdr.offset;
                                state_d = ST_MASKED;
                            end
                        end
                        OP_IMM: begin
                            imm_v_d   = 1'b1;
                            imm_off_d = hdr.offset;
                            imm_dat_d = hdr.wide;
                        end
                        OP_RESTART: begin
                            rst_v_d    = 1'b1;
                            rst_addr_d = hdr.restart;
                        end
                        OP_GATHER: begin
                            g_off_d  = hdr.offset;
                            g_ins_d  = hdr.g_ins;
                            g_type_d = hdr.g_type;
                            g_cnt_d  = hdr.g_cnt;
                            state_d  = ST_GATHER_ADDR;
                        end
                        OP_EXTEND: begin
                            lock_idx_d = hdr.lock_idx;
                            if (hdr.subop == SUB_W'(0))      acq_v_d = 1'b1;
                            else if (hdr.subop == SUB_W'(1)) rel_v_d = 1'b1;
                            else                             err_d   = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_SEQ: begin
                if (in_valid) begin
                    wr_v_d   = 1'b1;
                    wr_off_d = off_q;
                    wr_dat_d = in_data;
                    off_d    = off_q + 1'b1;
                    cnt_d    = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_d = ST_HEADER;
                end
            end
            ST_FIXED: begin
                if (in_valid) begin
                    wr_v_d   = 1'b1;
                    wr_off_d = off_q;
                    wr_dat_d = in_data;
                    cnt_d    = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_d = ST_HEADER;
                end
            end
            ST_MASKED: begin
                if (in_valid) begin
                    wr_v_d   = 1'b1;
                    wr_off_d = off_q + OFF_W'(walk_idx);
                    wr_dat_d = in_data;
                    mask_d   = walk_rest;
                    if (walk_rest == '0) state_d = ST_HEADER;
                end
            end
            ST_GATHER_ADDR: begin
                if (in_valid) begin
                    gth_v_d    = 1'b1;
                    gth_addr_d = in_data;
                    state_d    = ST_HEADER;
                end
            end
            default: state_d = ST_HEADER;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HEADER;
            off_q    <= '0;
            cnt_q    <= '0;
            mask_q   <= '0;
            g_off_q  <= '0;
            g_ins_q  <= 1'b0;
            g_type_q <= 1'b0;
            g_cnt_q  <= '0;
        end else begin
            state_q  <= state_d;
            off_q    <= off_d;
            cnt_q    <= cnt_d;
            mask_q   <= mask_d;
            g_off_q  <= g_off_d;
            g_ins_q  <= g_ins_d;
            g_type_q <= g_type_d;
            g_cnt_q  <= g_cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid       <= 1'b0;
            wr_offset      <= '0;
            wr_data        <= '0;
            class_valid    <= 1'b0;
            class_id       <= '0;
            imm_valid      <= 1'b0;
            imm_offset     <= '0;
            imm_data       <= '0;
            restart_valid  <= 1'b0;
            restart_addr   <= '0;
            gather_valid   <= 1'b0;
            gather_offset  <= '0;
            gather_insert  <= 1'b0;
            gather_type    <= 1'b0;
            gather_count   <= '0;
            gather_addr    <= '0;
            lock_acq_valid <= 1'b0;
            lock_rel_valid <= 1'b0;
            lock_index     <= '0;
            ext_error      <= 1'b0;
        end else begin
            wr_valid       <= wr_v_d;
            wr_offset      <= wr_off_d;
            wr_data        <= wr_dat_d;
            class_valid    <= cls_v_d;
            class_id       <= cls_id_d;
            imm_valid      <= imm_v_d;
            imm_offset     <= imm_off_d;
            imm_data       <= imm_dat_d;
            restart_valid  <= rst_v_d;
            restart_addr   <= rst_addr_d;
            gather_valid   <= gth_v_d;
            gather_addr    <= gth_addr_d;
            if (gth_v_d) begin
                gather_offset <= g_off_q;
                gather_insert <= g_ins_q;
                gather_type   <= g_type_q;
                gather_count  <= g_cnt_q;
            end
            lock_acq_valid <= acq_v_d;
            lock_rel_valid <= rel_v_d;
            lock_index     <= lock_idx_d;
            ext_error      <= err_d;
        end
    end
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] hdr_top,
    input logic       busy,
    input logic       wr_valid,
    input logic       class_valid,
    input logic       imm_valid,
    input logic       restart_valid,
    input logic       gather_valid,
    input logic       lock_acq_valid,
    input logic       lock_rel_valid,
    input logic       ext_error
);
    logic hdr_strobe, pay_strobe;
    assign hdr_strobe = class_valid | imm_valid | restart_valid |
                        lock_acq_valid | lock_rel_valid | ext_error;
    assign pay_strobe = wr_valid | gather_valid;

    AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
        in_ready); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, class_valid, imm_valid, restart_valid,
                  gather_valid, lock_acq_valid, lock_rel_valid, ext_error})); // R13

    AST_PAYLOAD_NO_HDR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy) |=> !hdr_strobe); // R12

    AST_HEADER_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> !pay_strobe); // R12

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(busy) && !hdr_strobe && !pay_strobe)); // R13

    AST_EXT_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && hdr_top[7:4] == 4'hE && hdr_top[3:1] != 3'b000)
        |=> ext_error); // R10
endmodule

bind cmd_stream_parser cmdp_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .hdr_top        (in_data[31:24]),
    .busy           (busy),
    .wr_valid       (wr_valid),
    .class_valid    (class_valid),
    .imm_valid      (imm_valid),
    .restart_valid  (restart_valid),
    .gather_valid   (gather_valid),
    .lock_acq_valid (lock_acq_valid),
    .lock_rel_valid (lock_rel_valid),
    .ext_error      (ext_error)
);

// File: tb/cmd_stream_parser_tb_top.sv
module cmd_stream_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid, class_valid, imm_valid, restart_valid, gather_valid;
    logic        lock_acq_valid, lock_rel_valid, ext_error, busy;
    logic        gather_insert, gather_type;
    logic [11:0] wr_offset, imm_offset, gather_offset;
    logic [31:0] wr_data, restart_addr, gather_addr;
    logic [9:0]  class_id;
    logic [15:0] imm_data;
    logic [13:0] gather_count;
    logic [7:0]  lock_index;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmd_stream_parser dut_i (.*);

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nstrobe();
        return int'(wr_valid) + int'(class_valid) + int'(imm_valid) +
               int'(restart_valid) + int'(gather_valid) + int'(lock_acq_valid) +
               int'(lock_rel_valid) + int'(ext_error);
    endfunction

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_write(input logic [11:0] off, input logic [31:0] d,
                                input string tag);
        chk(wr_valid && nstrobe() == 1, {tag, " wr_valid"}, wr_valid, 1);
        chk(wr_offset == off, {tag, " offset"}, wr_offset, off);
        chk(wr_data == d, {tag, " data"}, wr_data, d);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(nstrobe() == 0, "R1 strobes after reset", nstrobe(), 0);
        chk(in_ready, "R1 ready", in_ready, 1);

        // R2 R3 every class mask
        for (int m = 0; m < 64; m++) begin
            logic [11:0] base;
            logic [9:0]  cid;
            base = 12'hFFC;
            cid  = 10'((m * 13) & 10'h3FF);
            send({4'h0, base, cid, 6'(m)});
            chk(class_valid && class_id == cid, "R2 class strobe", class_id, cid);
            chk(busy == (m != 0), "R2 payload expected", busy, m != 0);
            for (int b = 0; b < 6; b++) begin
                if (m[b]) begin
                    send(32'(m * 256 + b));
                    expect_write(12'(base + 12'(b)), 32'(m * 256 + b), "R3");
                end
            end
            chk(!busy, "R3 end of mask", busy, 0);
        end

        // R6 masked write sweep
        for (int k = 0; k < 20; k++) begin
            logic [15:0] m;
            logic [11:0] base;
            if (k < 16)       m = 16'h1 << k;
            else if (k == 16) m = 16'hFFFF;
            else if (k == 17) m = 16'h8001;
            else if (k == 18) m = 16'h5AA5;
            else              m = 16'h0000;
            base = 12'hFF8 + 12'(k);
            send({4'h3, base, m});
            chk(busy == (m != 0), "R6 busy after header", busy, m != 0);
            chk(nstrobe() == 0, "R6 header silent", nstrobe(), 0);
            for (int b = 0; b < 16; b++) begin
                if (m[b]) begin
                    send(32'hC0DE_0000 + 32'(b));
                    expect_write(12'(base + 12'(b)), 32'hC0DE_0000 + 32'(b), "R6");
                end
            end
            chk(!busy, "R6 end of mask", busy, 0);
        end

        // R4 stepping writes, with wrap and zero count
        for (int c = 0; c < 4; c++) begin
            int n;
            n = (c == 3) ? 0 : 2 * c + 1;
            send({4'h1, 12'hFFE, 16'(n)});
            chk(busy == (n != 0), "R4 busy after header", busy, n != 0);
            for (int i = 0; i < n; i++) begin
                send(32'hA000_0000 + 32'(i));
                expect_write(12'hFFE + 12'(i), 32'hA000_0000 + 32'(i), "R4");
            end
            chk(!busy, "R4 done", busy, 0);
        end

        // R5 fixed writes
        send({4'h2, 12'h123, 16'd4});
        for (int i = 0; i < 4; i++) begin
            send(32'hB000_0000 + 32'(i));
            expect_write(12'h123, 32'hB000_0000 + 32'(i), "R5");
        end
        chk(!busy, "R5 done", busy, 0);

        // R13 stall inside a payload
        send({4'h1, 12'h040, 16'd2});
        send(32'h1111_1111);
        expect_write(12'h040, 32'h1111_1111, "R13 pre-stall");
        idle(3);
        chk(busy, "R13 busy held in stall", busy, 1);
        chk(nstrobe() == 0, "R13 no strobe in stall", nstrobe(), 0);
        send(32'h2222_2222);
        expect_write(12'h041, 32'h2222_2222, "R13 post-stall");
        chk(!busy, "R13 done", busy, 0);

        // R7 immediates and one-cycle pulse
        for (int i = 0; i < 4; i++) begin
            logic [11:0] o;
            logic [15:0] d;
            o = 12'(i * 12'h3A1);
            d = 16'(i * 16'h4B2D + 7);
            send({4'h4, o, d});
            chk(imm_valid && imm_offset == o, "R7 imm offset", imm_offset, o);
            chk(imm_data == d, "R7 imm data", imm_data, d);
            chk(!busy, "R7 no payload", busy, 0);
        end
        idle(1);
        chk(!imm_valid, "R13 single-cycle pulse", imm_valid, 0);

        // R8 restart
        send(32'h5ABC_DEF1);
        chk(restart_valid && restart_addr == 32'hABCD_EF10, "R8 restart addr",
            restart_addr, 32'hABCD_EF10);
        chk(!busy, "R8 no payload", busy, 0);

        // R9 gather
        for (int g = 0; g < 4; g++) begin
            logic [11:0] o;
            logic [13:0] n;
            o = 12'h700 + 12'(g);
            n = 14'(g * 14'h0FED + 1);
            send({4'h6, o, g[1], g[0], n});
            chk(!gather_valid && busy, "R9 waits for address", busy, 1);
            send(32'hDEAD_0000 + 32'(g));
            chk(gather_valid && gather_addr == 32'hDEAD_0000 + 32'(g), "R9 addr",
                gather_addr, 32'hDEAD_0000 + 32'(g));
            chk(gather_offset == o && gather_count == n, "R9 offset/count",
                {gather_offset, gather_count}, {o, n});
            chk(gather_insert == g[1] && gather_type == g[0], "R9 flags",
                {gather_insert, gather_type}, {g[1], g[0]});
            chk(!busy, "R9 done", busy, 0);
        end

        // R10 every extended sub-operation
        for (int s = 0; s < 16; s++) begin
            logic [7:0] idx;
            idx = 8'(s * 17);
            send({4'hE, 4'(s), 16'h0, idx});
            chk(lock_acq_valid == (s == 0), "R10 acquire", lock_acq_valid, s == 0);
            chk(lock_rel_valid == (s == 1), "R10 release", lock_rel_valid, s == 1);
            chk(ext_error == (s > 1), "R10 error", ext_error, s > 1);
            if (s < 2) chk(lock_index == idx, "R10 index", lock_index, idx);
            chk(!busy, "R10 no payload", busy, 0);
        end

        // R11 unassigned opcodes
        for (int op = 7; op < 16; op++) begin
            if (op != 14) begin
                send({4'(op), 28'h0012345});
                chk(nstrobe() == 0 && !busy, "R11 ignored", nstrobe(), 0);
                send({4'h4, 12'h0AB, 16'h00CD});
                chk(imm_valid && imm_data == 16'h00CD, "R11 next is header",
                    imm_data, 16'h00CD);
            end
        end

        // R1 reset mid-payload
        send({4'h1, 12'h010, 16'd5});
        send(32'h0);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        chk(!busy, "R1 reset clears busy", busy, 0);
        send({4'h4, 12'h055, 16'h0066});
        chk(imm_valid && imm_offset == 12'h055, "R1 header after reset",
            imm_offset, 12'h055);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule